// File: doc/BRIEF.md
# Audio serial clock and frame generator

This block is the master timing source of a stereo audio serial port. From a fast system clock it derives one bit clock and two word-select strobes, one for the playback path (`lrck`) and one for the capture path (`adws`). Each path's sample rate is the reference sample rate divided by an integer ratio. The path with the smaller ratio runs the faster strobe and sets the bit rate. The slower strobe is built from whole frames of the faster one, so it can only change level on a fast-frame boundary.

Two framing modes set the number of bit clocks in one fast frame. Fixed mode always uses 256. Continuous mode uses twice the selected word length. A one-cycle frame-start pulse marks the beginning of each left-channel slot of each strobe. A one-cycle marker also flags the first system-clock cycle of every bit, which is where a neighbouring shifter changes its data.

Settings are captured when `run` is first seen high. Two cases are refused: a combination that cannot be framed (fixed mode with a 48 kHz reference in left-justified format), and ratios whose quotient is not an integer. In either case the block raises `cfg_err` and stays idle.

Top module: `audio_frame_clkgen`

## Requirements
- R1: After reset, `busy` and `cfg_err` are low. While `busy` is low, `bclk`, `bclk_fall`, `lrck`, `adws`, `play_fs` and `cap_fs` are all low.
- R2: The launch happens on a clock edge where `run` is high, the block is idle and `cfg_err` is low, and the settings are legal. In the cycle after that edge `busy` is high and the first cycle of bit 0 begins, with both frame-start pulses high.
- R3: Every bit lasts 2×HALF_DIV system clocks. `bclk` is low for the first HALF_DIV of them and high for the rest. `bclk_fall` is high only in the first cycle of each bit.
- R4: A fast frame holds 256 bits when `fixed_mode`=1. Otherwise it holds twice the word length, where `wl_sel` values 0, 1, 2 and 3 select 16, 20, 24 and 32 bits.
- R5: The faster strobe shows the left level during the first half of the frame's bits and the opposite level during the second half. The left level is 0 for `fmt` 0 (I2S) and for `fmt` 3, which is treated as I2S. It is 1 for `fmt` 1 (left-justified) and `fmt` 2 (right-justified).
- R6: A ratio of 0 counts as 1, which is the reference rate. The path with the smaller ratio owns the faster strobe; on a tie, playback owns it. The slower strobe repeats every k fast frames, with k = larger ratio / smaller ratio.
- R7: When k=1 the slower strobe equals the faster one. When k≥2 it shows the left level for the first floor(k/2) fast frames of its period and the right level for the rest, so it only changes at fast-frame boundaries.
- R8: `play_fs` and `cap_fs` are high for one cycle at the start of each left slot of their own strobe. That is every fast frame for the faster strobe, and every k-th fast frame (starting at frame 0) for the slower one.
- R9: With `fixed_mode`=1, `base_48k`=1 and `fmt`=1, a run request sets `cfg_err` high in the next cycle and `busy` stays low.
- R10: If the larger ratio is not a whole multiple of the smaller one, a run request also sets `cfg_err` and leaves `busy` low. `cfg_err` stays high while `run` stays high and clears the cycle after `run` goes low.
- R11: Ratios, word length, format and mode are captured at launch. Changing them while `busy` is high has no effect on any output.
- R12: When `run` is sampled low, the next cycle has `busy` low and every output idle as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Request to generate clocks |
| fixed_mode | input | 1 | 1: 256 bits per fast frame; 0: twice the word length |
| base_48k | input | 1 | Reference sample rate is in the 48 kHz family |
| fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 treated as I2S |
| wl_sel | input | 2 | Word length: 16, 20, 24, 32 bits |
| play_div | input | DIV_W | Playback ratio to the reference rate (0 counts as 1) |
| cap_div | input | DIV_W | Capture ratio to the reference rate (0 counts as 1) |
| bclk | output | 1 | Bit clock level |
| bclk_fall | output | 1 | First system-clock cycle of each bit |
| lrck | output | 1 | Playback word-select strobe |
| adws | output | 1 | Capture word-select strobe |
| play_fs | output | 1 | Playback left-slot start pulse |
| cap_fs | output | 1 | Capture left-slot start pulse |
| busy | output | 1 | Clocks are running |
| cfg_err | output | 1 | Requested settings were refused |

## Verification
The bench builds the block with HALF_DIV=1 and DIV_W=3. With those values every bit takes two cycles, and ratios run from 0 to 7. That keeps each run short enough to sweep every ratio pair that divides evenly, for all four word lengths in continuous mode, and to cover k values from 1 to 7, including both odd and even slow periods. Fixed-mode runs then cover the 256-bit frame and the legal neighbours of the refused combination. Further runs cover the zero-ratio case, the non-integer quotient and recovery after an error. Every cycle of every run is compared with an arithmetic model of the elapsed cycle count.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_20 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_e;

    localparam int unsigned FIXED_FRAME_BITS = 256;
    localparam int unsigned NB_W = $clog2(FIXED_FRAME_BITS) + 1;
    localparam int unsigned BC_W = NB_W - 1;

    typedef struct packed {
        logic [NB_W-1:0] nbits;
        logic            left_lvl;
        logic            play_fast;
    } frame_cfg_t;

    localparam frame_cfg_t CFG_RESET = '{
        nbits:     NB_W'(FIXED_FRAME_BITS),
        left_lvl:  1'b0,
        play_fast: 1'b1
    };

    function automatic logic [NB_W-1:0] frame_bits(input logic fixed, input wlen_e wl);
        logic [NB_W-1:0] word;
        unique case (wl)
            WL_16:   word = NB_W'(16);
            WL_20:   word = NB_W'(20);
            WL_24:   word = NB_W'(24);
            default: word = NB_W'(32);
        endcase
        return fixed ? NB_W'(FIXED_FRAME_BITS) : (word << 1);
    endfunction

    function automatic logic left_level(input fmt_e f);
        return (f == FMT_LEFT) || (f == FMT_RIGHT);
    endfunction

endpackage

// File: rtl/audclk_cfg_check.sv
module audclk_cfg_check
    import audclk_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic             fixed_mode,
    input  logic             base_48k,
    input  logic [1:0]       fmt,
    input  logic [1:0]       wl_sel,
    input  logic [DIV_W-1:0] play_div,
    input  logic [DIV_W-1:0] cap_div,
    output frame_cfg_t       cfg,
    output logic [DIV_W-1:0] ratio_k,
    output logic             illegal
);

    logic [DIV_W-1:0] p_eff;
    logic [DIV_W-1:0] c_eff;
    logic [DIV_W-1:0] fast_r;
    logic [DIV_W-1:0] slow_r;
    logic [DIV_W-1:0] rem;
    logic             play_fast;
    logic             bad_combo;

    always_comb begin
        p_eff     = (play_div == '0) ? DIV_W'(1) : play_div;
        c_eff     = (cap_div == '0) ? DIV_W'(1) : cap_div;
        play_fast = (p_eff <= c_eff);
        fast_r    = play_fast ? p_eff : c_eff;
        slow_r    = play_fast ? c_eff : p_eff;
        ratio_k   = slow_r / fast_r;
        rem       = slow_r % fast_r;
        bad_combo = fixed_mode && base_48k && (fmt_e'(fmt) == FMT_LEFT);
        illegal   = bad_combo || (rem != '0);
        cfg.nbits     = frame_bits(fixed_mode, wlen_e'(wl_sel));
        cfg.left_lvl  = left_level(fmt_e'(fmt));
        cfg.play_fast = play_fast;
    end

endmodule

// File: rtl/audclk_bit_timer.sv
module audclk_bit_timer #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic bclk,
    output logic bit_start,
    output logic bit_last
);

    localparam int unsigned HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);

    logic [HC_W-1:0] hcnt;
    logic            half;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            hcnt <= '0;
            half <= 1'b0;
        end else if (hcnt == HC_LAST) begin
            hcnt <= '0;
            half <= ~half;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign bclk      = run_en && half;
    assign bit_start = run_en && !half && (hcnt == '0);
    assign bit_last  = run_en && half && (hcnt == HC_LAST);

    AST_BIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (bit_last && run_en) |=> (bit_start || !run_en)); // R3

endmodule

// File: rtl/audclk_frame_seq.sv
module audclk_frame_seq
    import audclk_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             bit_start,
    input  logic             bit_last,
    input  frame_cfg_t       cfg,
    input  logic [DIV_W-1:0] ratio_k,
    output logic             fast_ws,
    output logic             slow_ws,
    output logic             fast_fs,
    output logic             slow_fs
);

    logic [BC_W-1:0]  bcnt;
    logic [DIV_W-1:0] frm;
    logic [BC_W-1:0]  last_bit;
    logic [BC_W-1:0]  half_bits;
    logic [DIV_W-1:0] last_frm;
    logic             fast_left;
    logic             slow_left;

    always_comb begin
        last_bit  = BC_W'(cfg.nbits - 1'b1);
        half_bits = BC_W'(cfg.nbits >> 1);
        last_frm  = ratio_k - DIV_W'(1);
        fast_left = (bcnt < half_bits);
        slow_left = (ratio_k == DIV_W'(1)) ? fast_left : (frm < (ratio_k >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            bcnt <= '0;
            frm  <= '0;
        end else if (bit_last) begin
            if (bcnt == last_bit) begin
                bcnt <= '0;
                frm  <= (frm == last_frm) ? '0 : frm + 1'b1;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    assign fast_ws = run_en && (fast_left ? cfg.left_lvl : !cfg.left_lvl);
    assign slow_ws = run_en && (slow_left ? cfg.left_lvl : !cfg.left_lvl);
    assign fast_fs = bit_start && (bcnt == '0);
    assign slow_fs = fast_fs && (frm == '0);

    AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        run_en |-> (bcnt <= last_bit)); // R4
    AST_FRAME_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        run_en |-> (frm < ratio_k)); // R7

endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
    import audclk_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned DIV_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             fixed_mode,
    input  logic             base_48k,
    input  logic [1:0]       fmt,
    input  logic [1:0]       wl_sel,
    input  logic [DIV_W-1:0] play_div,
    input  logic [DIV_W-1:0] cap_div,
    output logic             bclk,
    output logic             bclk_fall,
    output logic             lrck,
    output logic             adws,
    output logic             play_fs,
    output logic             cap_fs,
    output logic             busy,
    output logic             cfg_err
);

    frame_cfg_t       cfg_req;
    frame_cfg_t       cfg_q;
    logic [DIV_W-1:0] k_req;
    logic [DIV_W-1:0] k_q;
    logic             illegal;
    logic             bit_last;
    logic             fast_ws;
    logic             slow_ws;
    logic             fast_fs;
    logic             slow_fs;

    audclk_cfg_check #(.DIV_W(DIV_W)) u_check (
        .fixed_mode (fixed_mode),
        .base_48k   (base_48k),
        .fmt        (fmt),
        .wl_sel     (wl_sel),
        .play_div   (play_div),
        .cap_div    (cap_div),
        .cfg        (cfg_req),
        .ratio_k    (k_req),
        .illegal    (illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cfg_err <= 1'b0;
            cfg_q   <= CFG_RESET;
            k_q     <= DIV_W'(1);
        end else if (!run) begin
            busy    <= 1'b0;
            cfg_err <= 1'b0;
        end else if (!busy && !cfg_err) begin
            if (illegal) begin
                cfg_err <= 1'b1;
            end else begin
                busy  <= 1'b1;
                cfg_q <= cfg_req;
                k_q   <= k_req;
            end
        end
    end

    audclk_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_en    (busy),
        .bclk      (bclk),
        .bit_start (bclk_fall),
        .bit_last  (bit_last)
    );

    audclk_frame_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run_en    (busy),
        .bit_start (bclk_fall),
        .bit_last  (bit_last),
        .cfg       (cfg_q),
        .ratio_k   (k_q),
        .fast_ws   (fast_ws),
        .slow_ws   (slow_ws),
        .fast_fs   (fast_fs),
        .slow_fs   (slow_fs)
    );

    assign lrck    = cfg_q.play_fast ? fast_ws : slow_ws;
    assign adws    = cfg_q.play_fast ? slow_ws : fast_ws;
    assign play_fs = cfg_q.play_fast ? fast_fs : slow_fs;
    assign cap_fs  = cfg_q.play_fast ? slow_fs : fast_fs;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bclk && !bclk_fall && !lrck && !adws && !play_fs && !cap_fs)); // R1
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy); // R9
    AST_FS_ON_BIT: assert property (@(posedge clk) disable iff (rst)
        (play_fs || cap_fs) |-> bclk_fall); // R8
    AST_WS_ON_BIT: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (lrck != $past(lrck))) |-> bclk_fall); // R5
    AST_SLOW_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (k_q > DIV_W'(1)) && (slow_ws != $past(slow_ws))) |-> fast_fs); // R7
    AST_STOP: assert property (@(posedge clk) disable iff (rst)
        !run |=> !busy); // R12

endmodule

// File: tb/test_audio_frame_clkgen.sv
module test_audio_frame_clkgen;

    localparam int H  = 1;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          run;
    logic          fixed_mode;
    logic          base_48k;
    logic [1:0]    fmt;
    logic [1:0]    wl_sel;
    logic [DW-1:0] play_div;
    logic [DW-1:0] cap_div;
    logic          bclk, bclk_fall, lrck, adws, play_fs, cap_fs, busy, cfg_err;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    audio_frame_clkgen #(.HALF_DIV(H), .DIV_W(DW)) i_audio_frame_clkgen (
        .clk(clk), .rst(rst), .run(run), .fixed_mode(fixed_mode), .base_48k(base_48k),
        .fmt(fmt), .wl_sel(wl_sel), .play_div(play_div), .cap_div(cap_div),
        .bclk(bclk), .bclk_fall(bclk_fall), .lrck(lrck), .adws(adws),
        .play_fs(play_fs), .cap_fs(cap_fs), .busy(busy), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int word_len(input int wl);
        case (wl)
            0: return 16;
            1: return 20;
            2: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic run_case(input int fx, input int b48, input int fm, input int wl,
                            input int p, input int c);
        int pe, ce, fast, k, n, len, lvl, bit_i, frame_i, pos;
        logic pfast, left_f, left_s, fws, sws, ffs, sfs, exp_bclk, exp_fall;
        pe = (p == 0) ? 1 : p;
        ce = (c == 0) ? 1 : c;
        pfast = (pe <= ce);
        fast = pfast ? pe : ce;
        k = (pfast ? ce : pe) / fast;
        n = fx ? 256 : 2 * word_len(wl);
        lvl = (fm == 1 || fm == 2) ? 1 : 0;
        len = 2 * k * n * 2 * H;
        fixed_mode = fx[0]; base_48k = b48[0]; fmt = fm[1:0]; wl_sel = wl[1:0];
        play_div = DW'(p); cap_div = DW'(c);
        run = 1'b1;
        @(posedge clk);
        for (int t = 0; t < len; t++) begin
            #1;
            pos = t % (2 * H);
            exp_bclk = (pos >= H);
            exp_fall = (pos == 0);
            bit_i = (t / (2 * H)) % n;
            frame_i = (t / (2 * H * n)) % k;
            left_f = (bit_i < n / 2);
            left_s = (k == 1) ? left_f : (frame_i < k / 2);
            fws = left_f ? lvl[0] : !lvl[0];
            sws = left_s ? lvl[0] : !lvl[0];
            ffs = ((t % (2 * H * n)) == 0);
            sfs = ffs && (frame_i == 0);
            // R2 R3 R4 R5 R6 R7 R8 R11: full output vector against the model
            check("R2/R3/R4/R5/R6/R7/R8/R11",
                  {25'd0, busy, bclk, bclk_fall, lrck, adws, play_fs, cap_fs},
                  {25'd0, 1'b1, exp_bclk, exp_fall,
                   pfast ? fws : sws, pfast ? sws : fws,
                   pfast ? ffs : sfs, pfast ? sfs : ffs});
            if (t == 3) begin
                play_div = DW'(p + 3);
                cap_div  = DW'(c + 5);
                wl_sel   = wl_sel ^ 2'd1;
                fmt      = fmt ^ 2'd1;
                fixed_mode = ~fixed_mode;
            end
            @(posedge clk);
        end
        #1 run = 1'b0;
        @(posedge clk);
        #1;
        check("R12", {25'd0, busy, bclk, bclk_fall, lrck, adws, play_fs, cap_fs}, 32'd0);
    endtask

    task automatic err_case(input int fx, input int b48, input int fm, input int wl,
                            input int p, input int c, input string req);
        fixed_mode = fx[0]; base_48k = b48[0]; fmt = fm[1:0]; wl_sel = wl[1:0];
        play_div = DW'(p); cap_div = DW'(c);
        run = 1'b1;
        @(posedge clk);
        #1 check(req, {30'd0, cfg_err, busy}, 32'd2);
        repeat (3) @(posedge clk);
        #1 check(req, {25'd0, cfg_err, busy, bclk, lrck, adws, play_fs, cap_fs}, 32'h40);
        run = 1'b0;
        @(posedge clk);
        #1 check(req, {30'd0, cfg_err, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; run = 1'b0; fixed_mode = 1'b0; base_48k = 1'b0;
        fmt = 2'd0; wl_sel = 2'd0; play_div = '0; cap_div = '0;
        repeat (3) @(posedge clk);
        #1 check("R1", {24'd0, busy, cfg_err, bclk, bclk_fall, lrck, adws, play_fs, cap_fs}, 32'd0);
        rst = 1'b0;
        @(posedge clk);
        #1 check("R1", {24'd0, busy, cfg_err, bclk, bclk_fall, lrck, adws, play_fs, cap_fs}, 32'd0);

        // R4 R6 R7: every evenly dividing ratio pair, all word lengths, continuous mode
        for (int wl = 0; wl < 4; wl++)
            for (int p = 1; p < 8; p++)
                for (int c = 1; c < 8; c++)
                    if (((p > c) ? p % c : c % p) == 0)
                        run_case(0, 0, (p + c + wl) % 4, wl, p, c);

        // R4 fixed frames, legal neighbours of the refused combination
        run_case(1, 0, 1, 0, 1, 1);
        run_case(1, 1, 2, 0, 2, 1);
        run_case(1, 1, 0, 3, 1, 2);
        run_case(0, 1, 1, 2, 3, 3);

        // R6 zero ratio counts as one
        run_case(0, 0, 0, 0, 0, 3);
        run_case(0, 0, 1, 1, 4, 0);

        // R9 R10 refusals, then recovery
        err_case(1, 1, 1, 0, 1, 1, "R9");
        err_case(1, 1, 1, 2, 1, 2, "R9");
        err_case(0, 0, 0, 0, 2, 3, "R10");
        err_case(0, 0, 2, 1, 5, 2, "R10");
        run_case(0, 0, 2, 1, 2, 4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule